// File: doc/BRIEF.md
# Single-wire UART datagram slave

This block sits on a half-duplex serial line that idles high and carries 8N1 bytes, least significant bit first. Each datagram opens with a sync byte. The slave times two falling edges inside that byte to learn the bit period, so the host may change its baud rate from one datagram to the next. The slave then collects the bytes that follow and keeps a running CRC over all of them, the sync byte included. It acts only when the CRC is correct and the node address matches its own.

An accepted write datagram produces a one-cycle register write strobe, with the register address and 32 data bits, and advances a datagram counter. An accepted read request first waits for a turnaround gap. The slave then enables its line driver and returns a reply datagram carrying the register contents, at the bit period it measured. After the stop bit of the reply's last byte, it releases the line. If the line stays idle for too long in the middle of a datagram, the partial datagram is dropped.

Top module: `swire_dgram_slave`

## Requirements
- R1: After reset, drv_en_o is 0, tx_o is 1, wr_stb_o is 0 and wr_cnt_o is 0.
- R2: The bit period is measured anew from the sync byte 0x05 of every datagram. It is half the clock count between the falling edges that open data bits 1 and 3. Datagrams at 13, 16 and 24 clocks per bit are all handled.
- R3: A write datagram has 8 bytes: 0x05, the node address, a register byte with bit 7 = 1, four data bytes with the most significant first, and the CRC. When accepted, it gives exactly one cycle of wr_stb_o, with reg_addr_o equal to register byte bits 6:0 and wr_data_o equal to the data.
- R4: The CRC uses the polynomial x^8+x^2+x+1 with a start value of 0. It runs over every byte before the CRC byte, sync included, feeding each byte least significant bit first. On a mismatch the datagram is ignored: no strobe, no reply and no counter change.
- R5: A datagram whose node byte differs from node_i is ignored: no strobe, no reply and no counter change.
- R6: wr_cnt_o rises by exactly one for each accepted write datagram and holds at all other times.
- R7: A read request has 4 bytes: 0x05, the node address, a register byte with bit 7 = 0, and the CRC. When accepted, it is answered with 8 bytes at the learned bit period: 0x05, 0xFF, the register byte, rd_data_i with the most significant byte first, and a CRC computed as in R4.
- R8: The reply's first start bit begins between 8 and 10 bit periods after the request's stop bit ends. drv_en_o stays high through the stop bit of the last reply byte and falls right after it.
- R9: If the line stays idle for more than 63 measured bit periods after the sync byte and before the datagram is complete, the partial datagram is dropped. The next 0x05 byte then starts a fresh datagram.
- R10: drv_en_o is 0 at all times except while a reply is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Serial line as seen at the pad |
| node_i | input | 8 | This slave's node address |
| rd_data_i | input | 32 | Register contents at reg_addr_o |
| drv_en_o | output | 1 | Line driver enable |
| tx_o | output | 1 | Transmit data for the line driver |
| wr_stb_o | output | 1 | One-cycle register write strobe |
| reg_addr_o | output | 7 | Register address of the current datagram |
| wr_data_o | output | 32 | Write data, valid with wr_stb_o |
| wr_cnt_o | output | CW | Count of accepted write datagrams |

## Verification
The bench builds the block with its defaults: a 16-bit bit-period timer, an 8-bit counter, a 63-bit idle limit and a 9-bit turnaround. Those values keep a full datagram under two thousand cycles at 13 to 24 clocks per bit. That is enough to cover an odd bit period, a change of rate between datagrams, the idle-timeout drop and a complete reply with its turnaround window. Counter wrap-around and very slow rates that come near the timer's width lie outside what these values reach.

// File: rtl/swd_pkg.sv
package swd_pkg;
  localparam int BYTE_W = 8;
  localparam int DATA_W = 32;
  localparam logic [7:0] SYNC_BYTE  = 8'h05;
  localparam logic [7:0] REPLY_NODE = 8'hFF;

  // one byte through the CRC-8 (poly 0x07), low bit first
  function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] data);
    logic [7:0] c;
    logic [7:0] d;
    c = crc;
    d = data;
    for (int i = 0; i < 8; i++) begin
      if (c[7] ^ d[0]) c = {c[6:0], 1'b0} ^ 8'h07;
      else             c = {c[6:0], 1'b0};
      d = d >> 1;
    end
    return c;
  endfunction

  // CRC of a reply: sync, reply node, register byte, data MSB byte first
  function automatic logic [7:0] reply_crc(input logic [7:0] regb, input logic [DATA_W-1:0] data);
    logic [7:0] c;
    c = crc8_step(8'h00, SYNC_BYTE);
    c = crc8_step(c, REPLY_NODE);
    c = crc8_step(c, regb);
    for (int i = DATA_W / BYTE_W - 1; i >= 0; i--) c = crc8_step(c, data[i*BYTE_W +: BYTE_W]);
    return c;
  endfunction
endpackage

// File: rtl/swd_rx.sv
module swd_rx #(
  parameter int TW        = 16,
  parameter int IDLE_BITS = 63
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_i,
  input  logic          line_i,
  output logic [7:0]    byte_o,
  output logic          byte_vld_o,
  output logic          sync_o,
  output logic          abort_o,
  output logic [TW-1:0] bit_t_o,
  output logic          busy_o
);
  localparam int IW = $clog2(IDLE_BITS + 1);

  typedef enum logic [2:0] {R_IDLE, R_SYNC1, R_SYNC3, R_SYNCEND, R_GAP, R_DATA} rx_st_e;
  rx_st_e st;

  logic s1, s2, s3;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; s3 <= 1'b1;
    end else begin
      s1 <= line_i; s2 <= s1; s3 <= s2;
    end
  end
  wire line_s = s2;
  wire fall   = s3 & ~s2;

  // span between two falling edges covers two bit periods
  function automatic logic [TW-1:0] span_to_bit(input logic [TW-1:0] span);
    return span >> 1;
  endfunction

  logic [TW-1:0] span, tmr, bit_t;
  logic [IW-1:0] idle_n;
  logic [3:0]    bitn;
  logic [7:0]    sh;

  wire [TW-1:0] due      = (bitn == 4'd0) ? (bit_t >> 1) : bit_t;
  wire          samp     = (tmr == due - 1'b1);
  wire          bit_gone = (tmr == bit_t - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= R_IDLE; span <= '0; tmr <= '0; bit_t <= '0; idle_n <= '0;
      bitn <= '0; sh <= '0; byte_o <= '0;
      byte_vld_o <= 1'b0; sync_o <= 1'b0; abort_o <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      sync_o     <= 1'b0;
      abort_o    <= 1'b0;
      if (hold_i) st <= R_IDLE;
      else begin
        case (st)
          R_IDLE: if (fall) begin st <= R_SYNC1; span <= '0; end
          R_SYNC1: begin
            if (fall) begin st <= R_SYNC3; span <= {{(TW-1){1'b0}}, 1'b1}; end
            else if (&span) st <= R_IDLE;
            else span <= span + 1'b1;
          end
          R_SYNC3: begin
            if (fall) begin
              bit_t  <= span_to_bit(span);
              sync_o <= 1'b1;
              st     <= R_SYNCEND;
            end else if (&span) st <= R_IDLE;
            else span <= span + 1'b1;
          end
          R_SYNCEND: if (line_s) begin st <= R_GAP; tmr <= '0; idle_n <= '0; end
          R_GAP: begin
            if (fall) begin
              st <= R_DATA; tmr <= '0; bitn <= '0;
            end else if (bit_gone) begin
              tmr <= '0;
              if (idle_n == IW'(IDLE_BITS)) begin
                abort_o <= 1'b1;
                st      <= R_IDLE;
              end else idle_n <= idle_n + 1'b1;
            end else tmr <= tmr + 1'b1;
          end
          R_DATA: begin
            if (samp) begin
              tmr  <= '0;
              bitn <= bitn + 1'b1;
              if (bitn == 4'd0 && line_s) begin
                st <= R_GAP; idle_n <= '0;
              end
              if (bitn >= 4'd1 && bitn <= 4'd8) sh <= {line_s, sh[7:1]};
              if (bitn == 4'd9) begin
                byte_o     <= sh;
                byte_vld_o <= 1'b1;
                st         <= R_GAP;
                idle_n     <= '0;
              end
            end else tmr <= tmr + 1'b1;
          end
          default: st <= R_IDLE;
        endcase
      end
    end
  end

  assign bit_t_o = bit_t;
  assign busy_o  = (st != R_IDLE);

  // R9
  rx_abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> !busy_o);
  // R9
  rx_abort_from_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> $past(st == R_GAP));
endmodule

// File: rtl/swd_tx.sv
module swd_tx #(
  parameter int NB        = 8,
  parameter int TW        = 16,
  parameter int TURN_BITS = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [TW-1:0] bit_t_i,
  input  logic [NB*8-1:0] frame_i,
  output logic          tx_o,
  output logic          drv_o,
  output logic          busy_o
);
  localparam int FB = NB * 10;
  localparam int CW = $clog2(FB + TURN_BITS + 1);

  typedef enum logic [1:0] {T_IDLE, T_TURN, T_SEND} tx_st_e;
  tx_st_e st;

  logic [FB-1:0] line_bits, sh;
  logic [TW-1:0] tmr, bit_t;
  logic [CW-1:0] bitc;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    assign line_bits[g*10 +: 10] = {1'b1, frame_i[g*8 +: 8], 1'b0};
  end

  wire bit_gone = (tmr == bit_t - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= T_IDLE; sh <= '1; tmr <= '0; bit_t <= '0; bitc <= '0;
    end else begin
      case (st)
        T_IDLE: if (start_i) begin
          st <= T_TURN; tmr <= '0; bitc <= '0; bit_t <= bit_t_i; sh <= line_bits;
        end
        T_TURN: begin
          if (bit_gone) begin
            tmr <= '0;
            if (bitc == CW'(TURN_BITS - 1)) begin bitc <= '0; st <= T_SEND; end
            else bitc <= bitc + 1'b1;
          end else tmr <= tmr + 1'b1;
        end
        T_SEND: begin
          if (bit_gone) begin
            tmr <= '0;
            sh  <= sh >> 1;
            if (bitc == CW'(FB - 1)) st <= T_IDLE;
            else bitc <= bitc + 1'b1;
          end else tmr <= tmr + 1'b1;
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  assign drv_o  = (st == T_SEND);
  assign tx_o   = (st == T_SEND) ? sh[0] : 1'b1;
  assign busy_o = (st != T_IDLE);

  // R8
  drv_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_o) |-> tx_o && $past(tx_o));
  // R8
  turn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !drv_o);
endmodule

// File: rtl/swire_dgram_slave.sv
module swire_dgram_slave
  import swd_pkg::*;
#(
  parameter int TW        = 16,
  parameter int CW        = 8,
  parameter int IDLE_BITS = 63,
  parameter int TURN_BITS = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_i,
  input  logic [BYTE_W-1:0] node_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              drv_en_o,
  output logic              tx_o,
  output logic              wr_stb_o,
  output logic [6:0]        reg_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [CW-1:0]     wr_cnt_o
);
  localparam int WR_LEN    = 8;
  localparam int RD_LEN    = 4;
  localparam int REPLY_LEN = 8;
  localparam int IXW       = $clog2(WR_LEN);

  logic [7:0]    rx_byte;
  logic          rx_vld, rx_sync, rx_abort, rx_busy, rx_hold;
  logic [TW-1:0] bit_t;
  logic          tx_busy, tx_go;

  logic [IXW-1:0]    idx;
  logic [7:0]        crc_q, reg_q;
  logic              node_ok;
  logic [DATA_W-1:0] data_q;
  logic [REPLY_LEN*8-1:0] frame;

  // internal events named for the checks
  wire in_dg   = (idx != '0);
  wire dg_last = rx_vld && in_dg &&
                 ((idx == IXW'(RD_LEN - 1) && !reg_q[7]) || idx == IXW'(WR_LEN - 1));
  wire dg_good = dg_last && node_ok && (rx_byte == crc_q);

  assign rx_hold = tx_busy | dg_last;

  swd_rx #(.TW(TW), .IDLE_BITS(IDLE_BITS)) u_rx (
    .clk(clk), .rst_n(rst_n), .hold_i(rx_hold), .line_i(line_i),
    .byte_o(rx_byte), .byte_vld_o(rx_vld), .sync_o(rx_sync), .abort_o(rx_abort),
    .bit_t_o(bit_t), .busy_o(rx_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0; crc_q <= '0; reg_q <= '0; node_ok <= 1'b0; data_q <= '0;
      wr_stb_o <= 1'b0; wr_cnt_o <= '0; tx_go <= 1'b0;
    end else begin
      wr_stb_o <= 1'b0;
      tx_go    <= 1'b0;
      if (rx_sync) begin
        idx   <= IXW'(1);
        crc_q <= crc8_step(8'h00, SYNC_BYTE);
      end else if (rx_abort) begin
        idx <= '0;
      end else if (rx_vld && in_dg) begin
        if (dg_last) begin
          idx <= '0;
          if (dg_good && reg_q[7]) begin
            wr_stb_o <= 1'b1;
            wr_cnt_o <= wr_cnt_o + 1'b1;
          end
          if (dg_good && !reg_q[7]) tx_go <= 1'b1;
        end else begin
          crc_q <= crc8_step(crc_q, rx_byte);
          idx   <= idx + 1'b1;
          if (idx == IXW'(1))      node_ok <= (rx_byte == node_i);
          else if (idx == IXW'(2)) reg_q   <= rx_byte;
          else                     data_q  <= {data_q[DATA_W-9:0], rx_byte};
        end
      end
    end
  end

  assign reg_addr_o = reg_q[6:0];
  assign wr_data_o  = data_q;
  assign frame = {reply_crc(reg_q, rd_data_i),
                  rd_data_i[7:0], rd_data_i[15:8], rd_data_i[23:16], rd_data_i[31:24],
                  reg_q, REPLY_NODE, SYNC_BYTE};

  swd_tx #(.NB(REPLY_LEN), .TW(TW), .TURN_BITS(TURN_BITS)) u_tx (
    .clk(clk), .rst_n(rst_n), .start_i(tx_go), .bit_t_i(bit_t), .frame_i(frame),
    .tx_o(tx_o), .drv_o(drv_en_o), .busy_o(tx_busy)
  );

  // R3
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o);
  // R6
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb_o |-> $stable(wr_cnt_o));
  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> wr_cnt_o == CW'($past(wr_cnt_o) + 1'b1));
  // R10
  line_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_busy |-> !drv_en_o);
endmodule

// File: tb/sim_swire_dgram_slave.sv
module sim_swire_dgram_slave;
  localparam int CW = 8;
  localparam logic [7:0] MY_NODE = 8'h3C;

  typedef struct packed { logic [6:0] a; logic [31:0] d; } wr_t;

  logic clk = 1'b0, rst_n = 1'b0, host_q = 1'b1;
  logic drv_en, tx, wr_stb;
  logic [6:0] reg_addr;
  logic [31:0] wr_data, rd_data;
  logic [CW-1:0] wr_cnt;
  wire bus = drv_en ? tx : host_q;

  int errs = 0, checks = 0, bt = 16, exp_cnt = 0;
  bit reply_win = 1'b0, drv_seen = 1'b0, done = 1'b0;
  wr_t exp_q[$];

  always #5 clk = ~clk;

  function automatic logic [31:0] rd_model(input logic [6:0] a);
    return {8'hA5, 1'b0, a, 16'h1234 ^ {9'd0, a}};
  endfunction
  assign rd_data = rd_model(reg_addr);

  // serial form of the CRC: feedback bit enters at bit 0 and flips bits 1 and 2
  function automatic logic [7:0] crc_ref(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r;
    logic fb;
    r = c;
    for (int j = 0; j < 8; j++) begin
      fb = r[7] ^ b[j];
      r  = {r[6:2], r[1] ^ fb, r[0] ^ fb, fb};
    end
    return r;
  endfunction

  swire_dgram_slave u0 (
    .clk(clk), .rst_n(rst_n), .line_i(bus), .node_i(MY_NODE), .rd_data_i(rd_data),
    .drv_en_o(drv_en), .tx_o(tx), .wr_stb_o(wr_stb), .reg_addr_o(reg_addr),
    .wr_data_o(wr_data), .wr_cnt_o(wr_cnt)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // per-clock reference comparison
  always @(negedge clk) begin
    if (rst_n) begin
      if (drv_en) drv_seen = 1'b1;
      if (wr_stb) begin
        wr_t e;
        if (exp_q.size() == 0) chk(1'b0, "R4", "unexpected write strobe", {reg_addr, wr_data}, 0);
        else begin
          e = exp_q.pop_front();
          chk({reg_addr, wr_data} == e, "R3", "write address/data", {reg_addr, wr_data}, e);
        end
      end
      if (drv_en && !reply_win) chk(1'b0, "R10", "driver on outside reply", 1, 0);
      if (drv_en && !host_q)    chk(1'b0, "R10", "bus contention", 0, 1);
    end
  end

  task automatic send_bit(input logic v);
    host_q = v;
    repeat (bt) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    send_bit(1'b0);
    for (int j = 0; j < 8; j++) send_bit(b[j]);
    send_bit(1'b1);
  endtask

  task automatic idle(input int nbits);
    host_q = 1'b1;
    repeat (nbits * bt) @(negedge clk);
  endtask

  task automatic send_dg(input logic [7:0] b[8], input int n, input bit bad);
    logic [7:0] c;
    c = 8'h00;
    for (int i = 0; i < n - 1; i++) begin
      c = crc_ref(c, b[i]);
      send_byte(b[i]);
    end
    send_byte(c ^ (bad ? 8'h10 : 8'h00));
  endtask

  task automatic do_write(input logic [7:0] node, input logic [6:0] ra, input logic [31:0] d,
                          input bit bad, input string tag);
    logic [7:0] b[8];
    b = '{8'h05, node, {1'b1, ra}, d[31:24], d[23:16], d[15:8], d[7:0], 8'h00};
    if (node == MY_NODE && !bad) begin
      exp_q.push_back({ra, d});
      exp_cnt++;
    end
    send_dg(b, 8, bad);
    idle(12);
    chk(exp_q.size() == 0, tag, "expected write not seen", exp_q.size(), 0);
    chk(wr_cnt == CW'(exp_cnt), tag, "datagram counter (R6)", wr_cnt, exp_cnt);
  endtask

  task automatic do_read(input logic [7:0] node, input logic [6:0] ra, input bit bad,
                         input bit answer, input string tag);
    logic [7:0] b[8];
    logic [7:0] er[8];
    logic [7:0] got;
    logic [31:0] rv;
    logic [7:0] c;
    int w, pos, target;
    bit frame_ok;
    b = '{8'h05, node, {1'b0, ra}, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    drv_seen = 1'b0;
    reply_win = answer;
    send_dg(b, 4, bad);
    if (answer) begin
      rv = rd_model(ra);
      er = '{8'h05, 8'hFF, {1'b0, ra}, rv[31:24], rv[23:16], rv[15:8], rv[7:0], 8'h00};
      c = 8'h00;
      for (int i = 0; i < 7; i++) c = crc_ref(c, er[i]);
      er[7] = c;
      w = 0;
      while (!(drv_en && !bus) && w < 20 * bt) begin
        @(negedge clk);
        w++;
      end
      chk(drv_en && !bus, tag, "reply start bit", bus, 0);
      chk(w >= 8 * bt && w <= 10 * bt, "R8", "turnaround cycles", w, 8 * bt);
      pos = 0;
      for (int i = 0; i < 8; i++) begin
        frame_ok = 1'b1;
        got = 8'h00;
        for (int k = 0; k < 10; k++) begin
          target = (i * 10 + k) * bt + bt / 2;
          repeat (target - pos) @(negedge clk);
          pos = target;
          if (k == 0 && bus) frame_ok = 1'b0;
          if (k == 9 && !bus) frame_ok = 1'b0;
          if (k >= 1 && k <= 8) got[k-1] = bus;
        end
        chk(frame_ok, "R7", "reply byte framing", i, 1);
        chk(got == er[i], tag, "reply byte (R7)", got, er[i]);
      end
      repeat (80 * bt - 2 - pos) @(negedge clk);
      chk(drv_en == 1'b1, "R8", "driver held through last stop bit", drv_en, 1);
      repeat (3) @(negedge clk);
      chk(drv_en == 1'b0, "R8", "driver released after reply", drv_en, 0);
      reply_win = 1'b0;
      idle(4);
    end else begin
      idle(20);
      chk(!drv_seen, tag, "no reply expected", drv_seen, 0);
    end
    chk(wr_cnt == CW'(exp_cnt), tag, "counter unchanged by read (R6)", wr_cnt, exp_cnt);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(drv_en == 1'b0, "R1", "reset driver enable", drv_en, 0);
    chk(tx == 1'b1, "R1", "reset tx level", tx, 1);
    chk(wr_stb == 1'b0, "R1", "reset write strobe", wr_stb, 0);
    chk(wr_cnt == '0, "R1", "reset counter", wr_cnt, 0);
    idle(4);

    bt = 16;
    do_write(MY_NODE, 7'h21, 32'hDEADBEEF, 1'b0, "R3");
    do_write(MY_NODE, 7'h05, 32'h0000_0001, 1'b0, "R6");
    do_write(MY_NODE, 7'h10, 32'h1111_2222, 1'b1, "R4");
    do_write(8'h3D,   7'h10, 32'h3333_4444, 1'b0, "R5");

    bt = 24;
    do_read(MY_NODE, 7'h2A, 1'b0, 1'b1, "R7");
    do_read(MY_NODE, 7'h2B, 1'b1, 1'b0, "R4");
    do_read(8'h11,   7'h2B, 1'b0, 1'b0, "R5");

    bt = 13;
    do_write(MY_NODE, 7'h7F, 32'h8000_00FF, 1'b0, "R2");
    do_read(MY_NODE, 7'h01, 1'b0, 1'b1, "R2");

    // R9: partial datagram, long idle, then a fresh valid write
    bt = 16;
    send_byte(8'h05);
    send_byte(MY_NODE);
    send_byte(8'h85);
    idle(70);
    chk(wr_cnt == CW'(exp_cnt), "R9", "partial datagram left no trace", wr_cnt, exp_cnt);
    do_write(MY_NODE, 7'h33, 32'hCAFE_F00D, 1'b0, "R9");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule